// File: doc/BRIEF.md
# Vectored Interrupt Controller With Number-Indexed Enables

This block collects 64 level-sensitive interrupt sources and presents them to a processor as two request lines, a normal line and a fast line. It also reports which source the handler should service. Software reaches it through a simple 32-bit register port, word-addressed. Each source has an enable bit, a type bit that sends it to the fast line (1) or the normal line (0), a software force bit and a 4-bit priority. State that spans all 64 sources is split into a high word, for sources 32..63, and a low word, for sources 0..31.

Software can turn a single source on or off without a read-modify-write. It writes the source number to a write-only enable-by-number or disable-by-number register. On the normal line the controller arbitrates by priority above a programmable floor. The fast line reports the highest-numbered pending fast source. Both vector status words can be read. So can the raw inputs, the force bits and both pending sets.

Top module: `irqc_top`

## Requirements
- R1: A write of N (0..63) to the enable-by-number register (word 2, byte 0x08) sets enable bit N and leaves every other enable bit unchanged.
- R2: A write of N (0..63) to the disable-by-number register (word 3, byte 0x0C) clears enable bit N and leaves every other enable bit unchanged.
- R3: A by-number write whose value is 64 or more changes no enable bit. Both by-number registers read as zero.
- R4: Enable bits read and write as a high word at word 4 (0x10, sources 32..63, bit i = source 32+i) and a low word at word 5 (0x14, sources 0..31). Type bits use the same layout at words 6/7 (0x18/0x1C).
- R5: A source is pending when (raw input OR force bit) AND enable bit. It is normal-pending if its type bit is 0 and fast-pending if it is 1. Raw inputs read at words 18/19, force bits at 20/21, normal pending at 22/23 and fast pending at 24/25, each as a high/low pair.
- R6: Priority word x (x = 0..7) sits at byte 0x20 + 4*(7-x), that is word 15-x. It holds the 4-bit priority of source 8x+k in bits [4k+3:4k].
- R7: The normal vector status (word 16, 0x40) reports the pending normal source with the highest priority among those whose priority is greater than the mask level. Equal priorities go to the higher source number. Bits [31:16] hold the source number and bits [3:0] its priority. With no such source, bits [31:16] are 0xFFFF and bits [3:0] are 0.
- R8: The priority mask register (word 1, 0x04) is a 5-bit signed level in bits [4:0]. Writing all ones (-1) removes masking, so a priority-0 source qualifies. Level 0 blocks priority 0.
- R9: The fast vector status (word 17, 0x44) holds the highest-numbered fast-pending source in bits [31:16], or 0xFFFF when none is pending. Bits [3:0] read 0.
- R10: After reset all enable, type, force and priority bits are 0, the mask level is 0, both request lines are low and both vector fields read 0xFFFF.
- R11: The normal line is high exactly when the normal vector is valid. The fast line is high exactly when any fast source is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register word address (byte offset / 4) |
| wdata_i | input | 32 | Write data |
| src_i | input | 64 | Raw level-sensitive interrupt inputs |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| nrm_irq_o | output | 1 | Normal interrupt request |
| fst_irq_o | output | 1 | Fast interrupt request |

## Verification
The bench sends by-number writes with out-of-range values, 64 and above. A decoder that truncated these to six bits would wrongly enable or disable a low source, and the following readback shows it. Equal priorities on source 3 and source 56 test the tie-break, where a first-match arbiter would report the lower number. The mask level is moved across the winner's priority, so an off-by-one compare shows up, and the all-ones mask case exposes a design that treats -1 as 31. Routing a source to the fast line must remove it from the normal vector, and the bench checks that the reversed priority word placement maps each word to the correct eight sources.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NSRC  = 64;
  localparam int DW    = 32;
  localparam int PW    = 4;
  localparam int IDXW  = $clog2(NSRC);
  localparam int AW    = 5;
  localparam int NPRIW = NSRC / 8;
  localparam int MW    = PW + 1;
  localparam logic [15:0] VEC_NONE = 16'hFFFF;

  localparam logic [AW-1:0] W_CTRL   = 5'd0;
  localparam logic [AW-1:0] W_MASK   = 5'd1;
  localparam logic [AW-1:0] W_ENNUM  = 5'd2;
  localparam logic [AW-1:0] W_DISNUM = 5'd3;
  localparam logic [AW-1:0] W_ENH    = 5'd4;
  localparam logic [AW-1:0] W_ENL    = 5'd5;
  localparam logic [AW-1:0] W_TYH    = 5'd6;
  localparam logic [AW-1:0] W_TYL    = 5'd7;
  localparam logic [AW-1:0] W_PRI7   = 5'd8;
  localparam logic [AW-1:0] W_PRI0   = 5'd15;
  localparam logic [AW-1:0] W_NVEC   = 5'd16;
  localparam logic [AW-1:0] W_FVEC   = 5'd17;
  localparam logic [AW-1:0] W_RAWH   = 5'd18;
  localparam logic [AW-1:0] W_RAWL   = 5'd19;
  localparam logic [AW-1:0] W_FRCH   = 5'd20;
  localparam logic [AW-1:0] W_FRCL   = 5'd21;
  localparam logic [AW-1:0] W_NPH    = 5'd22;
  localparam logic [AW-1:0] W_NPL    = 5'd23;
  localparam logic [AW-1:0] W_FPH    = 5'd24;
  localparam logic [AW-1:0] W_FPL    = 5'd25;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [AW-1:0]            waddr_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [NSRC-1:0]          en_o,
  output logic [NSRC-1:0]          typ_o,
  output logic [NSRC-1:0]          frc_o,
  output logic [NSRC-1:0][PW-1:0]  prio_o,
  output logic [MW-1:0]            mask_o
);
  logic [NSRC-1:0] en_q, typ_q, frc_q;
  logic [MW-1:0]   mask_q;
  logic            num_ok;

  assign num_ok = (wdata_i[DW-1:IDXW] == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      typ_q  <= '0;
      frc_q  <= '0;
      mask_q <= '0;
    end else if (wr_en_i) begin
      case (waddr_i)
        W_MASK:   mask_q <= wdata_i[MW-1:0];
        W_ENNUM:  if (num_ok) en_q[wdata_i[IDXW-1:0]] <= 1'b1;
        W_DISNUM: if (num_ok) en_q[wdata_i[IDXW-1:0]] <= 1'b0;
        W_ENH:    en_q[NSRC-1:DW]  <= wdata_i;
        W_ENL:    en_q[DW-1:0]     <= wdata_i;
        W_TYH:    typ_q[NSRC-1:DW] <= wdata_i;
        W_TYL:    typ_q[DW-1:0]    <= wdata_i;
        W_FRCH:   frc_q[NSRC-1:DW] <= wdata_i;
        W_FRCL:   frc_q[DW-1:0]    <= wdata_i;
        default: ;
      endcase
    end
  end

  // priority words are stored in reverse address order
  for (genvar g = 0; g < NPRIW; g++) begin : g_pri
    localparam logic [AW-1:0] WADDR = W_PRI0 - AW'(g);
    for (genvar k = 0; k < 8; k++) begin : g_fld
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          prio_o[8*g+k] <= '0;
        else if (wr_en_i && waddr_i == WADDR) prio_o[8*g+k] <= wdata_i[PW*k +: PW];
      end
    end
  end

  assign en_o   = en_q;
  assign typ_o  = typ_q;
  assign frc_o  = frc_q;
  assign mask_o = mask_q;

  // R1
  en_num_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && waddr_i == W_ENNUM && wdata_i[DW-1:IDXW] == '0)
      |=> en_q[$past(wdata_i[IDXW-1:0])]);
  // R2
  dis_num_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && waddr_i == W_DISNUM && wdata_i[DW-1:IDXW] == '0)
      |=> !en_q[$past(wdata_i[IDXW-1:0])]);
  // R3
  num_oob_ign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (waddr_i == W_ENNUM || waddr_i == W_DISNUM) && wdata_i[DW-1:IDXW] != '0)
      |=> $stable(en_q));
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
  import irqc_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NSRC-1:0]          req_i,
  input  logic [NSRC-1:0][PW-1:0]  prio_i,
  input  logic [MW-1:0]            floor_i,
  output logic                     vld_o,
  output logic [IDXW-1:0]          idx_o,
  output logic [PW-1:0]            prio_o
);
  // ascending scan with >= lets the higher index win a tie
  always_comb begin
    vld_o  = 1'b0;
    idx_o  = '0;
    prio_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req_i[i] && ($signed({1'b0, prio_i[i]}) > $signed(floor_i)) &&
          (!vld_o || prio_i[i] >= prio_o)) begin
        vld_o  = 1'b1;
        idx_o  = IDXW'(i);
        prio_o = prio_i[i];
      end
    end
  end

  // R7
  arb_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> req_i[idx_o]);
  // R7
  arb_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> ($signed({1'b0, prio_o}) > $signed(floor_i)));
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [NSRC-1:0]  src_i,
  output logic [DW-1:0]    rdata_o,
  output logic             nrm_irq_o,
  output logic             fst_irq_o
);
  logic [NSRC-1:0]         en, typ, frc, act, npend, fpend;
  logic [NSRC-1:0][PW-1:0] prio;
  logic [MW-1:0]           mask;
  logic                    n_vld, f_vld;
  logic [IDXW-1:0]         n_idx, f_idx;
  logic [PW-1:0]           n_pri, f_pri;
  logic [DW-1:0]           nvec, fvec;
  logic [NPRIW-1:0][DW-1:0] pri_word;
  logic [AW-1:0]           pdiff;

  irqc_regs i_regs (
    .clk_i, .rst_ni, .wr_en_i,
    .waddr_i (addr_i),
    .wdata_i,
    .en_o    (en),
    .typ_o   (typ),
    .frc_o   (frc),
    .prio_o  (prio),
    .mask_o  (mask)
  );

  assign act   = (src_i | frc) & en;
  assign npend = act & ~typ;
  assign fpend = act & typ;

  irqc_arb i_nrm_arb (
    .clk_i, .rst_ni,
    .req_i   (npend),
    .prio_i  (prio),
    .floor_i (mask),
    .vld_o   (n_vld),
    .idx_o   (n_idx),
    .prio_o  (n_pri)
  );

  // fast line: flat priority, no floor -> highest number wins
  irqc_arb i_fst_arb (
    .clk_i, .rst_ni,
    .req_i   (fpend),
    .prio_i  ('0),
    .floor_i ('1),
    .vld_o   (f_vld),
    .idx_o   (f_idx),
    .prio_o  (f_pri)
  );

  assign nvec = n_vld ? {{(16-IDXW){1'b0}}, n_idx, 12'h0, n_pri} : {VEC_NONE, 16'h0};
  assign fvec = f_vld ? {{(16-IDXW){1'b0}}, f_idx, 12'h0, f_pri} : {VEC_NONE, 16'h0};

  for (genvar g = 0; g < NPRIW; g++) begin : g_pw
    for (genvar k = 0; k < 8; k++) begin : g_pf
      assign pri_word[g][PW*k +: PW] = prio[8*g+k];
    end
  end

  assign pdiff = W_PRI0 - addr_i;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      W_MASK: rdata_o = {{(DW-MW){mask[MW-1]}}, mask};
      W_ENH:  rdata_o = en[NSRC-1:DW];
      W_ENL:  rdata_o = en[DW-1:0];
      W_TYH:  rdata_o = typ[NSRC-1:DW];
      W_TYL:  rdata_o = typ[DW-1:0];
      W_NVEC: rdata_o = nvec;
      W_FVEC: rdata_o = fvec;
      W_RAWH: rdata_o = src_i[NSRC-1:DW];
      W_RAWL: rdata_o = src_i[DW-1:0];
      W_FRCH: rdata_o = frc[NSRC-1:DW];
      W_FRCL: rdata_o = frc[DW-1:0];
      W_NPH:  rdata_o = npend[NSRC-1:DW];
      W_NPL:  rdata_o = npend[DW-1:0];
      W_FPH:  rdata_o = fpend[NSRC-1:DW];
      W_FPL:  rdata_o = fpend[DW-1:0];
      default: if (addr_i >= W_PRI7 && addr_i <= W_PRI0) rdata_o = pri_word[pdiff[2:0]];
    endcase
  end

  assign nrm_irq_o = n_vld;
  assign fst_irq_o = |fpend;

  // R5
  pend_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (npend & fpend) == '0);
  // R9
  fst_highest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    f_vld |-> ((fpend >> f_idx) >> 1) == '0);
  // R11
  fst_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fst_irq_o == f_vld);
  // R11
  nrm_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nrm_irq_o == (rdata_o[31:16] != VEC_NONE) || addr_i != W_NVEC);
endmodule

// File: tb/test_irqc_top.sv
`timescale 1ns/1ps
module test_irqc_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [63:0] src = '0;
  logic [31:0] rdata;
  logic        nrm_irq, fst_irq;

  always #2.5 clk = ~clk;

  irqc_top i_irqc_top (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .src_i(src), .rdata_o(rdata),
    .nrm_irq_o(nrm_irq), .fst_irq_o(fst_irq)
  );

  typedef struct {
    logic        lines;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t exp_q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [63:0] m_en = '0, m_ty = '0, m_fr = '0;
  logic [3:0]  m_pr [64];
  logic [4:0]  m_mask = '0;

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(posedge clk); #1;
      if (exp_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = exp_q.pop_front();
        act = it.lines ? {30'd0, fst_irq, nrm_irq} : rdata;
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    case (a)
      5'd1: m_mask = d[4:0];
      5'd2: if (d < 64) m_en[d[5:0]] = 1'b1;
      5'd3: if (d < 64) m_en[d[5:0]] = 1'b0;
      5'd4: m_en[63:32] = d;
      5'd5: m_en[31:0]  = d;
      5'd6: m_ty[63:32] = d;
      5'd7: m_ty[31:0]  = d;
      5'd20: m_fr[63:32] = d;
      5'd21: m_fr[31:0]  = d;
      default: if (a >= 8 && a <= 15)
                 for (int k = 0; k < 8; k++) m_pr[8*(15-a)+k] = d[4*k +: 4];
    endcase
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk(input logic [4:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    addr = a;
    exp_q.push_back('{1'b0, e, tag});
    @(posedge clk); #2;
  endtask

  task automatic chk_lines(input logic f, input logic n, input string tag);
    @(negedge clk);
    exp_q.push_back('{1'b1, {30'd0, f, n}, tag});
    @(posedge clk); #2;
  endtask

  task automatic set_src(input logic [63:0] v);
    @(negedge clk);
    src = v;
  endtask

  function automatic logic qualifies(input int i, input int p);
    if (!(((src[i] | m_fr[i]) & m_en[i]) && !m_ty[i])) return 1'b0;
    if (int'(m_pr[i]) != p) return 1'b0;
    if (m_mask[4]) return 1'b1;
    return p > int'(m_mask[3:0]);
  endfunction

  // search from top priority, top number downwards
  function automatic logic [31:0] exp_nvec();
    for (int p = 15; p >= 0; p--)
      for (int i = 63; i >= 0; i--)
        if (qualifies(i, p)) return {16'(i), 12'h0, 4'(p)};
    return 32'hFFFF_0000;
  endfunction

  function automatic logic [31:0] exp_fvec();
    for (int i = 63; i >= 0; i--)
      if ((src[i] | m_fr[i]) & m_en[i] & m_ty[i]) return {16'(i), 16'h0};
    return 32'hFFFF_0000;
  endfunction

  initial begin
    for (int i = 0; i < 64; i++) m_pr[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    chk(5'd4, 32'h0, "R10 enable high");
    chk(5'd5, 32'h0, "R10 enable low");
    chk(5'd1, 32'h0, "R10 mask");
    chk(5'd16, 32'hFFFF_0000, "R10 normal vector");
    chk(5'd17, 32'hFFFF_0000, "R10 fast vector");
    chk_lines(1'b0, 1'b0, "R10 lines");

    wr(5'd2, 32'd5);
    wr(5'd2, 32'd40);
    chk(5'd5, 32'h0000_0020, "R1 enable low");
    chk(5'd4, 32'h0000_0100, "R1 enable high");
    chk(5'd2, 32'h0, "R3 enable-by-number reads zero");
    chk(5'd3, 32'h0, "R3 disable-by-number reads zero");

    wr(5'd2, 32'd64);
    wr(5'd2, 32'h105);
    chk(5'd5, 32'h0000_0020, "R3 oob enable low");
    chk(5'd4, 32'h0000_0100, "R3 oob enable high");

    wr(5'd3, 32'd5);
    chk(5'd5, 32'h0, "R2 disable low");
    chk(5'd4, 32'h0000_0100, "R2 others kept");
    wr(5'd3, 32'd72);
    chk(5'd4, 32'h0000_0100, "R3 oob disable");

    wr(5'd4, 32'hF000_0000);
    wr(5'd5, 32'h0000_000F);
    chk(5'd4, 32'hF000_0000, "R4 enable high word");
    chk(5'd5, 32'h0000_000F, "R4 enable low word");
    wr(5'd4, 32'h0);
    wr(5'd5, 32'h0);
    chk(5'd4, 32'h0, "R4 clear high");
    wr(5'd6, 32'h8000_0001);
    chk(5'd6, 32'h8000_0001, "R4 type high word");
    wr(5'd6, 32'h0);

    wr(5'd8, 32'h1234_5678);
    wr(5'd15, 32'h8888_8888);
    chk(5'd8, 32'h1234_5678, "R6 priority word 7");
    chk(5'd15, 32'h8888_8888, "R6 priority word 0");

    wr(5'd1, 32'hFFFF_FFFF);
    wr(5'd2, 32'd56);
    wr(5'd2, 32'd63);
    set_src(64'h8100_0000_0000_0000);
    chk(5'd16, 32'h0038_0008, "R6 source 56 priority 8 wins");

    wr(5'd21, 32'h8);
    wr(5'd2, 32'd3);
    chk(5'd16, exp_nvec(), "R7 tie to higher number");
    chk(5'd23, 32'h8, "R5 normal pending low");
    chk(5'd22, 32'h8100_0000, "R5 normal pending high");
    chk(5'd18, 32'h8100_0000, "R5 raw high");
    chk(5'd21, 32'h8, "R5 force low");

    wr(5'd1, 32'd8);
    chk(5'd16, 32'hFFFF_0000, "R7 mask equal blocks");
    chk_lines(1'b0, 1'b0, "R11 normal low when masked");
    wr(5'd1, 32'd7);
    chk(5'd16, 32'h0038_0008, "R7 mask below admits");
    chk_lines(1'b0, 1'b1, "R11 normal high");
    wr(5'd3, 32'd56);
    chk(5'd16, exp_nvec(), "R7 source 3 next");
    chk(5'd16, 32'h0003_0008, "R7 source 3 vector");

    wr(5'd3, 32'd3);
    wr(5'd3, 32'd63);
    wr(5'd2, 32'd10);
    wr(5'd21, 32'h400);
    wr(5'd1, 32'd0);
    chk(5'd16, 32'hFFFF_0000, "R8 level 0 blocks priority 0");
    wr(5'd1, 32'h1F);
    chk(5'd16, 32'h000A_0000, "R8 all ones admits priority 0");

    wr(5'd2, 32'd63);
    wr(5'd7, 32'h400);
    wr(5'd6, 32'h8000_0000);
    chk(5'd16, 32'hFFFF_0000, "R5 fast sources leave normal vector");
    chk(5'd17, exp_fvec(), "R9 highest fast");
    chk(5'd17, 32'h003F_0000, "R9 source 63");
    chk(5'd24, 32'h8000_0000, "R5 fast pending high");
    chk(5'd25, 32'h400, "R5 fast pending low");
    chk_lines(1'b1, 1'b0, "R11 fast only");
    wr(5'd3, 32'd63);
    chk(5'd17, 32'h000A_0000, "R9 source 10");
    wr(5'd3, 32'd10);
    chk(5'd17, 32'hFFFF_0000, "R9 none");
    chk_lines(1'b0, 1'b0, "R11 both low");

    wait (exp_q.size() == 0);
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule